// File: doc/BRIEF.md
# Compare and Skip Condition Unit

This block executes the register-compare instructions and the skip-next-instruction tests of an 8-bit microcontroller core. The core presents the current instruction word, the operand values read from the register file and from the low I/O space, the present carry and zero flags, and the instruction word that follows. The block returns the register and I/O addresses to read, and, one clock after issue, a set of updated status flags with a write enable per flag, plus a skip request for the fetch stage.

Compares subtract without writing any general register. The compare-with-carry form chains multi-byte compares: it subtracts the incoming carry and only keeps the zero flag set when every byte so far was zero. Skip tests cover register equality, a single bit of a register and a single bit of one of the 32 lowest I/O registers. When a skip is taken and the following instruction is a two-word long jump or long call, a second flag tells fetch to discard both words.

Top module: `cmp_skip_unit`

## Requirements
- R1: Address outputs are combinational from the instruction: for two-register forms `rd_sel_o` = {instr[8], instr[7:4]} and `rr_sel_o` = {instr[9], instr[3:0]}; for compare-immediate (instr[15:12] = 0011) `rd_sel_o` = 16 + instr[7:4]; for register-bit skips `rr_sel_o` = instr[8:4]; `io_addr_o` = instr[7:3].
- R2: Compare (instr[15:10] = 000101) and compare-immediate (K = {instr[11:8], instr[3:0]}) compute R = (Rd − B) mod 256 and, one clock after `issue_i`, drive `flags_we_o` = 6'h3F with `flags_o` bit order {H,S,V,N,Z,C} (bit 0 = C); Z = 1 when R = 0.
- R3: C is the borrow out of bit 7 and H is the borrow out of bit 3.
- R4: V = (Rd7 & ~B7 & ~R7) | (~Rd7 & B7 & R7), N = R7, S = N xor V.
- R5: Compare-with-carry (instr[15:10] = 000001) also subtracts `carry_i`; Z = `zero_i` when R = 0 and 0 otherwise.
- R6: Compare-and-skip-if-equal (instr[15:10] = 000100) sets `skip_o` when Rd = Rr and writes no flag.
- R7: Register-bit skips (1111 110r rrrr 0bbb skips on clear, 1111 111r rrrr 0bbb skips on set) test bit b of `rr_val_i`; the form with instr[3] = 1 is not recognised.
- R8: I/O-bit skips (1001 1001 AAAA Abbb on clear, 1001 1011 AAAA Abbb on set) test bit b of `io_val_i`.
- R9: `skip_two_o` is 1 exactly when `skip_o` is 1 and `next_instr_i` is a long jump or call (next[15:9] = 1001010 and next[3:2] = 11).
- R10: With `issue_i` low, or an unrecognised opcode, the next cycle shows all flag enables, flags and skip outputs at 0.
- R11: Reset clears every registered output at once, whatever was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | Instruction word valid this cycle |
| instr_i | input | 16 | Instruction word |
| next_instr_i | input | 16 | Following instruction word |
| rd_val_i | input | 8 | Value of register at `rd_sel_o` |
| rr_val_i | input | 8 | Value of register at `rr_sel_o` |
| io_val_i | input | 8 | Value of I/O register at `io_addr_o` |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| rd_sel_o | output | 5 | First register address |
| rr_sel_o | output | 5 | Second register address |
| io_addr_o | output | 5 | Low I/O register address |
| flags_o | output | 6 | New flags {H,S,V,N,Z,C} |
| flags_we_o | output | 6 | Per-flag write enables, same order |
| skip_o | output | 1 | Discard the next instruction |
| skip_two_o | output | 1 | Next instruction is two words long |

## Verification
The bench targets the sign-boundary subtractions 0x80 − 0x01 and 0x7F − 0xFF, where a swapped overflow term flips V and S, and the nibble borrow 0x10 − 0x01, where a half-carry taken from the wrong bit leaves H clear. It runs compare-with-carry with the zero flag in and out, so a design that recomputes Z from the result alone sets Z where it must stay clear, and one that drops the carry-in misses the borrow from 0x00 − 0x00. Skip cases pair taken and not-taken tests with short and long following words, exposing a two-word flag raised without a skip, and the register-bit form with instr[3] set, which a loose decoder would accept.

// File: rtl/cs_pkg.sv
package cs_pkg;

  typedef enum logic [3:0] {
    OP_NONE,
    OP_CMP_REG,
    OP_CMP_CARRY,
    OP_CMP_IMM,
    OP_SKIP_EQ,
    OP_SKIP_RBC,
    OP_SKIP_RBS,
    OP_SKIP_IOC,
    OP_SKIP_IOS
  } op_e;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;
  localparam int NUM_FLAGS = 6;

  function automatic logic is_compare(op_e op);
    return (op == OP_CMP_REG) || (op == OP_CMP_CARRY) || (op == OP_CMP_IMM);
  endfunction

  // Two-word control transfer: 1001 010k kkkk 11ck
  function automatic logic is_long_transfer(logic [15:0] w);
    return (w[15:9] == 7'b1001010) && (w[3:2] == 2'b11);
  endfunction

endpackage

// File: rtl/cs_decode.sv
module cs_decode
  import cs_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 5,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic [INSTR_W-1:0] instr_i,
  output op_e                op_o,
  output logic [SEL_W-1:0]   rd_sel_o,
  output logic [SEL_W-1:0]   rr_sel_o,
  output logic [SEL_W-1:0]   io_addr_o,
  output logic [BIT_W-1:0]   bit_o,
  output logic [DATA_W-1:0]  imm_o
);

  always_comb begin
    op_o = OP_NONE;
    if (instr_i[15:10] == 6'b000101)      op_o = OP_CMP_REG;
    else if (instr_i[15:10] == 6'b000001) op_o = OP_CMP_CARRY;
    else if (instr_i[15:10] == 6'b000100) op_o = OP_SKIP_EQ;
    else if (instr_i[15:12] == 4'b0011)   op_o = OP_CMP_IMM;
    else if (instr_i[15:9] == 7'b1111110 && !instr_i[3]) op_o = OP_SKIP_RBC;
    else if (instr_i[15:9] == 7'b1111111 && !instr_i[3]) op_o = OP_SKIP_RBS;
    else if (instr_i[15:8] == 8'b10011001) op_o = OP_SKIP_IOC;
    else if (instr_i[15:8] == 8'b10011011) op_o = OP_SKIP_IOS;
  end

  // Register-bit skips carry their register in the field the compares use for Rd.
  always_comb begin
    if (op_o == OP_CMP_IMM) rd_sel_o = {1'b1, instr_i[7:4]};
    else                    rd_sel_o = instr_i[8:4];
    if (op_o == OP_SKIP_RBC || op_o == OP_SKIP_RBS) rr_sel_o = instr_i[8:4];
    else                                            rr_sel_o = {instr_i[9], instr_i[3:0]};
  end

  assign io_addr_o = instr_i[7:3];
  assign bit_o     = instr_i[BIT_W-1:0];
  assign imm_o     = {instr_i[11:8], instr_i[3:0]};

endmodule

// File: rtl/cs_sub_flags.sv
module cs_sub_flags
  import cs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int HALF_MSB = DATA_W / 2 - 1
) (
  input  logic [DATA_W-1:0]    a_i,
  input  logic [DATA_W-1:0]    b_i,
  input  logic                 cin_i,
  input  logic                 chain_z_i,
  input  logic                 zin_i,
  output logic [NUM_FLAGS-1:0] flags_o
);

  logic [DATA_W-1:0] diff;
  logic [DATA_W-1:0] borrow;
  logic              res_zero;

  assign diff = a_i - b_i - {{(DATA_W-1){1'b0}}, cin_i};

  // Borrow out of each bit position, recovered from operands and result.
  assign borrow = (~a_i & b_i) | (b_i & diff) | (diff & ~a_i);
  assign res_zero = (diff == '0);

  always_comb begin
    flags_o       = '0;
    flags_o[FL_C] = borrow[DATA_W-1];
    flags_o[FL_H] = borrow[HALF_MSB];
    flags_o[FL_N] = diff[DATA_W-1];
    flags_o[FL_V] = (a_i[DATA_W-1] & ~b_i[DATA_W-1] & ~diff[DATA_W-1]) |
                    (~a_i[DATA_W-1] & b_i[DATA_W-1] & diff[DATA_W-1]);
    flags_o[FL_S] = flags_o[FL_N] ^ flags_o[FL_V];
    flags_o[FL_Z] = chain_z_i ? (res_zero & zin_i) : res_zero;
  end

endmodule

// File: rtl/cs_skip_eval.sv
module cs_skip_eval
  import cs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] rd_i,
  input  logic [DATA_W-1:0] rr_i,
  input  logic [DATA_W-1:0] io_i,
  input  logic [BIT_W-1:0]  bit_i,
  output logic              skip_o
);

  logic reg_bit;
  logic io_bit;

  assign reg_bit = rr_i[bit_i];
  assign io_bit  = io_i[bit_i];

  always_comb begin
    unique case (op_i)
      OP_SKIP_EQ:  skip_o = (rd_i == rr_i);
      OP_SKIP_RBC: skip_o = ~reg_bit;
      OP_SKIP_RBS: skip_o = reg_bit;
      OP_SKIP_IOC: skip_o = ~io_bit;
      OP_SKIP_IOS: skip_o = io_bit;
      default:     skip_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cmp_skip_unit.sv
module cmp_skip_unit
  import cs_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int DATA_W  = 8,
  parameter int SEL_W   = 5,
  localparam int BIT_W  = $clog2(DATA_W)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 issue_i,
  input  logic [INSTR_W-1:0]   instr_i,
  input  logic [INSTR_W-1:0]   next_instr_i,
  input  logic [DATA_W-1:0]    rd_val_i,
  input  logic [DATA_W-1:0]    rr_val_i,
  input  logic [DATA_W-1:0]    io_val_i,
  input  logic                 carry_i,
  input  logic                 zero_i,
  output logic [SEL_W-1:0]     rd_sel_o,
  output logic [SEL_W-1:0]     rr_sel_o,
  output logic [SEL_W-1:0]     io_addr_o,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic [NUM_FLAGS-1:0] flags_we_o,
  output logic                 skip_o,
  output logic                 skip_two_o
);

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1] & rst_n;

  op_e               op;
  logic [BIT_W-1:0]  bit_idx;
  logic [DATA_W-1:0] imm;
  logic [NUM_FLAGS-1:0] alu_flags;
  logic              skip_raw;
  logic [DATA_W-1:0] operand_b;

  cs_decode #(.INSTR_W(INSTR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_decode (
    .instr_i   (instr_i),
    .op_o      (op),
    .rd_sel_o  (rd_sel_o),
    .rr_sel_o  (rr_sel_o),
    .io_addr_o (io_addr_o),
    .bit_o     (bit_idx),
    .imm_o     (imm)
  );

  assign operand_b = (op == OP_CMP_IMM) ? imm : rr_val_i;

  cs_sub_flags #(.DATA_W(DATA_W)) u_sub (
    .a_i       (rd_val_i),
    .b_i       (operand_b),
    .cin_i     ((op == OP_CMP_CARRY) & carry_i),
    .chain_z_i (op == OP_CMP_CARRY),
    .zin_i     (zero_i),
    .flags_o   (alu_flags)
  );

  cs_skip_eval #(.DATA_W(DATA_W)) u_skip (
    .op_i   (op),
    .rd_i   (rd_val_i),
    .rr_i   (rr_val_i),
    .io_i   (io_val_i),
    .bit_i  (bit_idx),
    .skip_o (skip_raw)
  );

  logic unused_next;
  assign unused_next = ^{next_instr_i[8:4], next_instr_i[1:0]};

  // Next-state
  logic [NUM_FLAGS-1:0] flags_d, we_d;
  logic                 skip_d, two_d;

  always_comb begin
    flags_d = '0;
    we_d    = '0;
    skip_d  = 1'b0;
    two_d   = 1'b0;
    if (issue_i) begin
      if (is_compare(op)) begin
        flags_d = alu_flags;
        we_d    = '1;
      end
      skip_d = skip_raw;
      two_d  = skip_raw & is_long_transfer(next_instr_i);
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      flags_o    <= '0;
      flags_we_o <= '0;
      skip_o     <= 1'b0;
      skip_two_o <= 1'b0;
    end else begin
      flags_o    <= flags_d;
      flags_we_o <= we_d;
      skip_o     <= skip_d;
      skip_two_o <= two_d;
    end
  end

  // Assertions
  p_skip_no_flags_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip_o |-> (flags_we_o == '0));

  p_two_needs_skip_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    skip_two_o |-> skip_o);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !issue_i |=> (flags_we_o == '0 && flags_o == '0 && !skip_o && !skip_two_o));

  p_sign_rule_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    flags_we_o[FL_S] |-> (flags_o[FL_S] == (flags_o[FL_N] ^ flags_o[FL_V])));

  p_chain_zero_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (issue_i && op == OP_CMP_CARRY && !zero_i) |=> (flags_we_o[FL_Z] && !flags_o[FL_Z]));

endmodule

// File: tb/cmp_skip_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_skip_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue_i;
  logic [15:0] instr_i, next_instr_i;
  logic [7:0]  rd_val_i, rr_val_i, io_val_i;
  logic        carry_i, zero_i;
  logic [4:0]  rd_sel_o, rr_sel_o, io_addr_o;
  logic [5:0]  flags_o, flags_we_o;
  logic        skip_o, skip_two_o;

  always #2 clk = ~clk;  // 250 MHz

  cmp_skip_unit dut_i (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .instr_i(instr_i),
    .next_instr_i(next_instr_i), .rd_val_i(rd_val_i), .rr_val_i(rr_val_i),
    .io_val_i(io_val_i), .carry_i(carry_i), .zero_i(zero_i),
    .rd_sel_o(rd_sel_o), .rr_sel_o(rr_sel_o), .io_addr_o(io_addr_o),
    .flags_o(flags_o), .flags_we_o(flags_we_o), .skip_o(skip_o),
    .skip_two_o(skip_two_o)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [15:0] ins;
    logic [7:0]  rd;
    logic [7:0]  rr;
    logic [7:0]  io;
    logic        cin;
    logic        zin;
    logic [15:0] nxt;
    logic [5:0]  we;
    logic [5:0]  fl;   // {H,S,V,N,Z,C}
    logic        sk;
    logic        two;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VECS [NV] = '{
    '{4'd2,  16'h1412, 8'h05, 8'h03, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h00, 1'b0, 1'b0}, // R2 plain
    '{4'd2,  16'h1412, 8'h80, 8'h80, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h02, 1'b0, 1'b0}, // R2 zero
    '{4'd3,  16'h1412, 8'h10, 8'h01, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h20, 1'b0, 1'b0}, // R3 nibble borrow
    '{4'd3,  16'h1412, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h35, 1'b0, 1'b0}, // R3 full borrow
    '{4'd4,  16'h1412, 8'h80, 8'h01, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h38, 1'b0, 1'b0}, // R4 neg->pos overflow
    '{4'd4,  16'h1412, 8'h7F, 8'hFF, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h0D, 1'b0, 1'b0}, // R4 pos->neg overflow
    '{4'd2,  16'h3402, 8'h42, 8'h99, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h02, 1'b0, 1'b0}, // R2 immediate equal
    '{4'd3,  16'h3A35, 8'h10, 8'h00, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h3F, 6'h21, 1'b0, 1'b0}, // R3 immediate borrow
    '{4'd5,  16'h0410, 8'h05, 8'h04, 8'h00, 1'b1, 1'b1, 16'h0000, 6'h3F, 6'h02, 1'b0, 1'b0}, // R5 Z kept
    '{4'd5,  16'h0410, 8'h05, 8'h04, 8'h00, 1'b1, 1'b0, 16'h0000, 6'h3F, 6'h00, 1'b0, 1'b0}, // R5 Z stays clear
    '{4'd5,  16'h0410, 8'h00, 8'h00, 8'h00, 1'b1, 1'b1, 16'h0000, 6'h3F, 6'h35, 1'b0, 1'b0}, // R5 carry-in borrow
    '{4'd6,  16'h1012, 8'h33, 8'h33, 8'h00, 1'b1, 1'b1, 16'h0000, 6'h00, 6'h00, 1'b1, 1'b0}, // R6 equal skip
    '{4'd9,  16'h1012, 8'h33, 8'h33, 8'h00, 1'b0, 1'b0, 16'h940C, 6'h00, 6'h00, 1'b1, 1'b1}, // R9 long next
    '{4'd6,  16'h1012, 8'h33, 8'h34, 8'h00, 1'b0, 1'b0, 16'h940C, 6'h00, 6'h00, 1'b0, 1'b0}, // R6 unequal
    '{4'd7,  16'hFC53, 8'h00, 8'hF7, 8'h00, 1'b0, 1'b0, 16'h940E, 6'h00, 6'h00, 1'b1, 1'b1}, // R7 clear bit 3, R9
    '{4'd7,  16'hFE57, 8'h00, 8'h7F, 8'h00, 1'b0, 1'b0, 16'h0000, 6'h00, 6'h00, 1'b0, 1'b0}, // R7 set bit 7 absent
    '{4'd7,  16'hFE50, 8'h00, 8'h01, 8'h00, 1'b0, 1'b0, 16'h9409, 6'h00, 6'h00, 1'b1, 1'b0}, // R7 set bit 0, short next
    '{4'd8,  16'h99FA, 8'h00, 8'h00, 8'h04, 1'b0, 1'b0, 16'h0000, 6'h00, 6'h00, 1'b0, 1'b0}, // R8 io clear test, bit set
    '{4'd8,  16'h9B04, 8'h00, 8'h00, 8'h10, 1'b0, 1'b0, 16'h940D, 6'h00, 6'h00, 1'b1, 1'b1}, // R8 io set, R9
    '{4'd10, 16'h0000, 8'hAA, 8'h55, 8'hFF, 1'b1, 1'b1, 16'h940C, 6'h00, 6'h00, 1'b0, 1'b0}, // R10 unknown op
    '{4'd10, 16'hFC5B, 8'h00, 8'h00, 8'h00, 1'b0, 1'b0, 16'h940C, 6'h00, 6'h00, 1'b0, 1'b0}  // R10/R7 instr[3]=1
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic iss);
    issue_i = iss; instr_i = v.ins; next_instr_i = v.nxt;
    rd_val_i = v.rd; rr_val_i = v.rr; io_val_i = v.io;
    carry_i = v.cin; zero_i = v.zin;
  endtask

  initial begin
    rst_n = 1'b0;
    drive(VECS[0], 1'b0);
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", {26'd0, flags_we_o}, 32'd0);
    check("R11", {30'd0, skip_o, skip_two_o}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 address decode
    instr_i = 16'h17FF; #1;
    check("R1", {22'd0, rd_sel_o, rr_sel_o}, {22'd0, 5'd31, 5'd31});
    instr_i = 16'h3A35; #1;
    check("R1", {27'd0, rd_sel_o}, 32'd19);
    instr_i = 16'hFC53; #1;
    check("R1", {27'd0, rr_sel_o}, 32'd5);
    instr_i = 16'h99FA; #1;
    check("R1", {27'd0, io_addr_o}, 32'd31);
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      issue_i = 1'b0;
      check($sformatf("R%0d vec %0d", VECS[i].req, i),
            {18'd0, flags_we_o, flags_o, skip_o, skip_two_o},
            {18'd0, VECS[i].we, VECS[i].fl, VECS[i].sk, VECS[i].two});
    end

    // R10 idle after a taken skip: outputs drop
    drive(VECS[11], 1'b1);
    @(negedge clk);
    drive(VECS[11], 1'b0);
    @(negedge clk);
    check("R10 idle", {18'd0, flags_we_o, flags_o, skip_o, skip_two_o}, 32'd0);

    // R11 reset clears a pending skip immediately
    drive(VECS[18], 1'b1);
    @(negedge clk);
    issue_i = 1'b0;
    check("R11 pre", {30'd0, skip_o, skip_two_o}, 32'd3);
    rst_n = 1'b0; #1;
    check("R11 async", {30'd0, skip_o, skip_two_o}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

endmodule